// File: doc/BRIEF.md
# Protected System Clock Controller

This block chooses which of four clock sources drives the CPU system clock and how far that source is divided. The division is modelled as a clock-enable pulse rather than a gated clock. Source 0 is the internal oscillator, and the block selects it at reset. Software changes the setting through a small register port. The configuration registers are write-locked. They accept a write only while the 16-bit protection register holds the unlock key 0x0096.

The block also tracks deep sleep. A sleep request that carries the deep-sleep qualifier stops the CPU clock enable. A four-bit keep mask then decides which sources go on running, for example to feed a real-time counter. The next wake event ends sleep. If the wake mode bit is set, a separate wake source and wake divider become the active setting on that exit. If it is clear, the setting from before sleep stays in force.

Register map (addr_i): 0 = protection key register, 1 = clock setting, 2 = sleep keep mask, 3 = reserved (reads 0). Clock setting bits: [1:0] source, [3:2] divider code, [5:4] wake source, [7:6] wake divider code, [8] wake mode. Keep mask bit i belongs to source i.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the source is 0, the divider code is 0, the keep mask is 0, the block is locked and awake, src_run_o is 4'b0001, and every register reads 0.
- R2: While the protection register does not hold 0x0096, writes to addresses 1 and 2 leave their contents and outputs unchanged.
- R3: After 0x0096 is written to address 0, writes to addresses 1 and 2 take effect at the write edge: readback, sel_src_o and sel_div_o follow from the next cycle on.
- R4: Writing any value other than 0x0096 to address 0 locks the block again from the next cycle on.
- R5: Address 0 reads back the last value written to it, and address 3 always reads 0.
- R6: Divider codes 0, 1, 2 and 3 give sys_clk_en_o high once every 1, 2, 4 and 8 cycles. The enable is high in the first cycle after an accepted setting write or a wake, and again every ratio cycles after that.
- R7: While awake, src_run_o is one-hot on the active source.
- R8: sleep_req_i with deep_i high puts the block asleep from the next cycle. sleep_req_i with deep_i low has no effect, and wake_i while awake has no effect.
- R9: While asleep, sys_clk_en_o is 0 and src_run_o equals the keep mask.
- R10: wake_i while asleep ends sleep from the next cycle. If the wake mode bit is 1, the wake source and wake divider code become the active source and divider code.
- R11: If the wake mode bit is 0, the source and divider code from before sleep are unchanged after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| sleep_req_i | input | 1 | Sleep request |
| deep_i | input | 1 | Deep-sleep qualifier |
| wake_i | input | 1 | Wake event (interrupt) |
| src_run_o | output | 4 | Per-source run request |
| sel_src_o | output | 2 | Active system clock source |
| sel_div_o | output | 2 | Active divider code |
| asleep_o | output | 1 | Deep sleep state |
| sys_clk_en_o | output | 1 | Divided system clock enable |

## Verification
Each register write, sleep entry and wake lands on a single clock edge. Its effect is visible on the ports one cycle after the stimulus is presented, and the read data then follows combinationally from the stored state. The bench drives inputs on the falling edge and checks results on the next falling edge, after the one rising edge that commits them. The divider enable is checked cycle by cycle against the count of cycles since the last restart, modulo the ratio. That count starts at 0 in the first cycle after the accepted write or the wake.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int DW     = 16;
  localparam int SRC_W  = 2;
  localparam int N_SRC  = 1 << SRC_W;
  localparam int DIV_W  = 2;
  localparam logic [DW-1:0] KEY = 16'h0096;
  localparam logic [SRC_W-1:0] RST_SRC = '0;

  typedef enum logic [1:0] {
    A_PROT = 2'd0,
    A_CFG  = 2'd1,
    A_KEEP = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             wk_mode;
    logic [DIV_W-1:0] wk_div;
    logic [SRC_W-1:0] wk_src;
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
  } clk_cfg_t;

  localparam int CFG_W = $bits(clk_cfg_t);
endpackage

// File: rtl/sysclk_prot.sv
module sysclk_prot
  import sysclk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] prot_o,
  output logic          unlock_o
);
  logic [DW-1:0] prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prot_q <= '0;
    else if (wr_i) prot_q <= wdata_i;
  end

  assign prot_o   = prot_q;
  assign unlock_o = (prot_q == KEY);
endmodule

// File: rtl/sysclk_cfg.sv
module sysclk_cfg
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cfg_i,
  input  logic             wr_keep_i,
  input  logic             unlock_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             sleep_req_i,
  input  logic             deep_i,
  input  logic             wake_i,
  output clk_cfg_t         cfg_o,
  output logic [N_SRC-1:0] keep_o,
  output logic             asleep_o,
  output logic             restart_o
);
  clk_cfg_t         cfg_q, cfg_d;
  logic [N_SRC-1:0] keep_q, keep_d;
  logic             asleep_q, asleep_d;
  logic             cfg_acc, keep_acc, wake_go;

  assign cfg_acc  = wr_cfg_i && unlock_i;
  assign keep_acc = wr_keep_i && unlock_i;
  assign wake_go  = asleep_q && wake_i;

  always_comb begin
    cfg_d    = cfg_q;
    keep_d   = keep_q;
    asleep_d = asleep_q;
    if (cfg_acc)  cfg_d  = clk_cfg_t'(wdata_i);
    if (keep_acc) keep_d = wdata_i[N_SRC-1:0];
    if (!asleep_q && sleep_req_i && deep_i) begin
      asleep_d = 1'b1;
    end else if (wake_go) begin
      asleep_d = 1'b0;
      // alternate setting on exit, write data loses to it
      if (cfg_d.wk_mode) begin
        cfg_d.src = cfg_d.wk_src;
        cfg_d.div = cfg_d.wk_div;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '{wk_mode: 1'b0, wk_div: '0, wk_src: '0, div: '0, src: RST_SRC};
      keep_q    <= '0;
      asleep_q  <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      keep_q    <= keep_d;
      asleep_q  <= asleep_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign keep_o    = keep_q;
  assign asleep_o  = asleep_q;
  assign restart_o = cfg_acc || wake_go;
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hold_i,
  input  logic             restart_i,
  output logic             en_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  // ratio 2**div, terminal count 2**div - 1
  assign lim = ~({CNT_W{1'b1}} << div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || restart_i) cnt_q <= '0;
    else if (cnt_q >= lim)      cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = !hold_i && (cnt_q == '0);
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             sleep_req_i,
  input  logic             deep_i,
  input  logic             wake_i,
  output logic [N_SRC-1:0] src_run_o,
  output logic [SRC_W-1:0] sel_src_o,
  output logic [DIV_W-1:0] sel_div_o,
  output logic             asleep_o,
  output logic             sys_clk_en_o
);
  logic [DW-1:0]    prot;
  logic             unlock;
  clk_cfg_t         cfg;
  logic [N_SRC-1:0] keep;
  logic             asleep, restart;

  sysclk_prot i_prot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && addr_i == A_PROT),
    .wdata_i  (wdata_i),
    .prot_o   (prot),
    .unlock_o (unlock)
  );

  sysclk_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_cfg_i    (wr_en_i && addr_i == A_CFG),
    .wr_keep_i   (wr_en_i && addr_i == A_KEEP),
    .unlock_i    (unlock),
    .wdata_i     (wdata_i[CFG_W-1:0]),
    .sleep_req_i (sleep_req_i),
    .deep_i      (deep_i),
    .wake_i      (wake_i),
    .cfg_o       (cfg),
    .keep_o      (keep),
    .asleep_o    (asleep),
    .restart_o   (restart)
  );

  sysclk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (cfg.div),
    .hold_i    (asleep),
    .restart_i (restart),
    .en_o      (sys_clk_en_o)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_run
    assign src_run_o[i] = asleep ? keep[i] : (cfg.src == SRC_W'(i));
  end

  always_comb begin
    unique case (addr_i)
      A_PROT:  rdata_o = prot;
      A_CFG:   rdata_o = {{(DW-CFG_W){1'b0}}, cfg};
      A_KEEP:  rdata_o = {{(DW-N_SRC){1'b0}}, keep};
      default: rdata_o = '0;
    endcase
  end

  assign sel_src_o = cfg.src;
  assign sel_div_o = cfg.div;
  assign asleep_o  = asleep;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk
  import sysclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             sleep_req_i,
  input logic             deep_i,
  input logic             wake_i,
  input logic [N_SRC-1:0] src_run_o,
  input logic [SRC_W-1:0] sel_src_o,
  input logic [DIV_W-1:0] sel_div_o,
  input logic             asleep_o,
  input logic             sys_clk_en_o,
  input logic             unlocked
);
  // R2
  locked_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CFG && !unlocked && !asleep_o) |=> ($stable(sel_src_o) && $stable(sel_div_o)));

  // R4
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_PROT && wdata_i != KEY) |=> !unlocked);

  // R6
  div_one_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && sel_div_o == '0) |-> sys_clk_en_o);

  // R7
  awake_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asleep_o |-> ($onehot(src_run_o) && src_run_o[sel_src_o]));

  // R8
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && sleep_req_i && deep_i) |=> asleep_o);

  // R8
  shallow_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && !(sleep_req_i && deep_i)) |=> !asleep_o);

  // R9
  sleep_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !sys_clk_en_o);

  // R10
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && wake_i) |=> !asleep_o);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .sleep_req_i  (sleep_req_i),
  .deep_i       (deep_i),
  .wake_i       (wake_i),
  .src_run_o    (src_run_o),
  .sel_src_o    (sel_src_o),
  .sel_div_o    (sel_div_o),
  .asleep_o     (asleep_o),
  .sys_clk_en_o (sys_clk_en_o),
  .unlocked     (unlock)
);

// File: tb/test_sysclk_ctrl.sv
module test_sysclk_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        sleep_req_i = 1'b0, deep_i = 1'b0, wake_i = 1'b0;
  logic [3:0]  src_run_o;
  logic [1:0]  sel_src_o, sel_div_o;
  logic        asleep_o, sys_clk_en_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  sysclk_ctrl i_sysclk_ctrl (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, return at the negedge after the commit edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    addr_i = a; #1;
    chk(req, rdata_o, exp);
  endtask

  function automatic logic [15:0] cfgw(int src, int dv, int wsrc, int wdv, int wm);
    return 16'(src | (dv << 2) | (wsrc << 4) | (wdv << 6) | (wm << 8));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 src", 16'(sel_src_o), 16'd0);
    chk("R1 div", 16'(sel_div_o), 16'd0);
    chk("R1 run", 16'(src_run_o), 16'h1);
    chk("R1 asleep", 16'(asleep_o), 16'd0);
    chk("R1 en", 16'(sys_clk_en_o), 16'd1);
    for (int a = 0; a < 4; a++) rd("R1 rd", 2'(a), 16'd0);

    // R2 locked writes ignored
    wr(2'd1, cfgw(3, 2, 1, 1, 1));
    rd("R2 cfg", 2'd1, 16'd0);
    chk("R2 src", 16'(sel_src_o), 16'd0);
    wr(2'd2, 16'hF);
    rd("R2 keep", 2'd2, 16'd0);

    // R3 unlock then write
    wr(2'd0, 16'h0096);
    rd("R5 prot", 2'd0, 16'h0096);
    wr(2'd2, 16'h5);
    rd("R3 keep", 2'd2, 16'h5);

    // R3 R6 R7 sweep every source/divider
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        wr(2'd1, cfgw(s, d, 0, 0, 0));
        rd("R3 cfg", 2'd1, cfgw(s, d, 0, 0, 0));
        chk("R3 src", 16'(sel_src_o), 16'(s));
        chk("R3 div", 16'(sel_div_o), 16'(d));
        for (int t = 0; t < 16; t++) begin
          chk("R6 en", 16'(sys_clk_en_o), 16'((t % (1 << d)) == 0));
          chk("R7 run", 16'(src_run_o), 16'(1 << s));
          @(negedge clk_i);
        end
      end
    end

    // R5 reserved
    rd("R5 rsvd", 2'd3, 16'd0);

    // R8 shallow sleep and stray wake ignored
    wr(2'd1, cfgw(2, 1, 0, 0, 0));
    sleep_req_i = 1'b1; deep_i = 1'b0;
    @(negedge clk_i); sleep_req_i = 1'b0;
    chk("R8 shallow", 16'(asleep_o), 16'd0);
    wake_i = 1'b1;
    @(negedge clk_i); wake_i = 1'b0;
    chk("R8 stray wake asleep", 16'(asleep_o), 16'd0);
    chk("R8 stray wake src", 16'(sel_src_o), 16'd2);

    // R8..R11 sleep sweep over keep masks and wake mode
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 16; k++) begin
        int ps, pd, es, ed;
        ps = (k + 1) % 4; pd = (k + 2) % 4;
        wr(2'd2, 16'(k));
        wr(2'd1, cfgw(ps, pd, k % 4, k / 4, m));
        sleep_req_i = 1'b1; deep_i = 1'b1;
        @(negedge clk_i); sleep_req_i = 1'b0; deep_i = 1'b0;
        chk("R8 asleep", 16'(asleep_o), 16'd1);
        for (int t = 0; t < 3; t++) begin
          chk("R9 en", 16'(sys_clk_en_o), 16'd0);
          chk("R9 run", 16'(src_run_o), 16'(k));
          @(negedge clk_i);
        end
        wake_i = 1'b1;
        @(negedge clk_i); wake_i = 1'b0;
        es = m ? k % 4 : ps;
        ed = m ? k / 4 : pd;
        chk("R10 awake", 16'(asleep_o), 16'd0);
        chk(m ? "R10 src" : "R11 src", 16'(sel_src_o), 16'(es));
        chk(m ? "R10 div" : "R11 div", 16'(sel_div_o), 16'(ed));
        for (int t = 0; t < 8; t++) begin
          chk("R6 wake en", 16'(sys_clk_en_o), 16'((t % (1 << ed)) == 0));
          @(negedge clk_i);
        end
      end
    end

    // R4 relock, R5 readback
    wr(2'd1, cfgw(1, 0, 0, 0, 0));
    wr(2'd0, 16'h1234);
    rd("R5 prot", 2'd0, 16'h1234);
    wr(2'd1, cfgw(3, 3, 0, 0, 0));
    rd("R4 cfg", 2'd1, cfgw(1, 0, 0, 0, 0));
    chk("R4 src", 16'(sel_src_o), 16'd1);
    wr(2'd2, 16'h9);
    rd("R4 keep", 2'd2, 16'hF);
    wr(2'd0, 16'h0097);
    wr(2'd1, cfgw(3, 3, 0, 0, 0));
    chk("R4 near key", 16'(sel_src_o), 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule